// File: doc/BRIEF.md
# Clear Channel Assessment Evaluator

This block produces the clear-channel flag that a packet radio's medium-access logic reads before it transmits. Each cycle it takes three inputs: a signed signal-strength sample with a valid strobe, a flag that is high while a frame is being received, and a signed energy threshold. It combines them according to a programmed decision mode. The energy test has asymmetric hysteresis. The channel turns clear only when the level falls below the threshold minus a programmable margin, and it turns busy once the level reaches the threshold. Between those two limits the previous energy verdict is kept.

A 32-bit control word sets the decision mode and the hysteresis margin, and a simple write/read port accesses it. A new mode is used from the next cycle in which a signal-strength sample is valid. The energy verdict that is held is not cleared when the mode changes. The flag is registered: each decision appears on the output one clock after the inputs that caused it.

Top module: `cca_eval`

## Requirements
- R1: After reset the control word reads 0 (mode 0, margin 0), `clear_o` is 1, and the held energy verdict is busy (0).
- R2: Mode 0 (control bits 4:3 = 00) keeps `clear_o` at 1 whatever the other inputs are.
- R3: In mode 1, a valid sample at or above the threshold makes the energy verdict busy. A valid sample below threshold minus margin makes it clear. A valid sample between those limits keeps the previous verdict. `clear_o` follows the verdict.
- R4: In mode 2, `clear_o` is 1 when `rx_active_i` is low and 0 when it is high. No valid strobe is needed.
- R5: In mode 3, `clear_o` is the energy verdict (as in R3) ANDed with the inverse of `rx_active_i`.
- R6: Control bits 2:0 hold the unsigned hysteresis margin in dB and bits 4:3 hold the mode. Bits 31:5 always read 0 and ignore writes. A write is visible on the read port from the next cycle.
- R7: The energy verdict changes only in cycles where `rssi_valid_i` is high.
- R8: Threshold minus margin is computed without wrapping. For example, threshold -125 with margin 7 gives -132, so no 8-bit sample lies below it.
- R9: `clear_o` is registered. It shows the decision formed from the inputs sampled at one rising edge, starting after that edge.
- R10: A mode written through the port takes effect at the first later cycle in which `rssi_valid_i` is high. The energy verdict is kept across the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rssi_i | input | 8 | Signal strength, two's-complement dBm |
| rssi_valid_i | input | 1 | Sample strobe for `rssi_i` |
| rx_active_i | input | 1 | High while a frame is being received |
| thr_i | input | 8 | Energy threshold, two's-complement dBm |
| reg_wr_i | input | 1 | Control word write enable |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Control word read data |
| clear_o | output | 1 | Registered clear-channel flag |

## Verification
A corrupted held energy verdict shows on `clear_o` in modes 1 and 3. It appears one clock after the first valid sample that falls inside the hysteresis band, because there the output simply repeats the stored value. A wrong effective-mode register shows up as soon as the inputs make the modes disagree, for example a frame in progress while the mode is 0. The bench sweeps the sample level up and down across every threshold/margin/mode combination in a small grid, with gaps in the strobe. It compares each cycle against an arithmetic model, so a fault is seen within one clock of the first input that exposes it.

// File: rtl/cca_pkg.sv
package cca_pkg;
  typedef enum logic [1:0] {
    CCA_FORCE  = 2'b00,
    CCA_ENERGY = 2'b01,
    CCA_FRAME  = 2'b10,
    CCA_BOTH   = 2'b11
  } cca_mode_e;
endpackage

// File: rtl/cca_cfg_reg.sv
module cca_cfg_reg
  import cca_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int HYST_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output cca_mode_e         mode_o,
  output logic [HYST_W-1:0] hyst_o
);
  localparam int UsedW = HYST_W + 2;

  logic [UsedW-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (wr_i) cfg_q <= wdata_i[UsedW-1:0];
  end

  assign rdata_o = {{(REG_W-UsedW){1'b0}}, cfg_q};
  assign mode_o  = cca_mode_e'(cfg_q[UsedW-1:HYST_W]);
  assign hyst_o  = cfg_q[HYST_W-1:0];

  p_wr_visible_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> rdata_o[UsedW-1:0] == $past(wdata_i[UsedW-1:0]));
  p_rsvd_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(rdata_o));
endmodule

// File: rtl/cca_energy_det.sv
module cca_energy_det #(
  parameter int RSSI_W = 8,
  parameter int HYST_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RSSI_W-1:0] rssi_i,
  input  logic              valid_i,
  input  logic [RSSI_W-1:0] thr_i,
  input  logic [HYST_W-1:0] hyst_i,
  output logic              energy_nxt_o
);
  localparam int DiffW = RSSI_W + 2;

  logic signed [DiffW-1:0] rssi_x, thr_x, hyst_x, low_x;
  logic energy_q, at_or_above, below_low;

  // sign-extend so thr - hyst cannot wrap
  assign rssi_x = {{2{rssi_i[RSSI_W-1]}}, rssi_i};
  assign thr_x  = {{2{thr_i[RSSI_W-1]}}, thr_i};
  assign hyst_x = {{(DiffW-HYST_W){1'b0}}, hyst_i};
  assign low_x  = thr_x - hyst_x;

  assign at_or_above = rssi_x >= thr_x;
  assign below_low   = rssi_x < low_x;

  always_comb begin
    energy_nxt_o = energy_q;
    if (valid_i) begin
      if (at_or_above)    energy_nxt_o = 1'b0;
      else if (below_low) energy_nxt_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) energy_q <= 1'b0;
    else         energy_q <= energy_nxt_o;
  end

  p_busy_at_thr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && $signed(rssi_i) >= $signed(thr_i)) |=> !energy_q);
  p_hold_no_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(energy_q));
endmodule

// File: rtl/cca_decide.sv
module cca_decide
  import cca_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      valid_i,
  input  logic      rx_active_i,
  input  cca_mode_e cfg_mode_i,
  input  logic      energy_nxt_i,
  output logic      clear_o
);
  cca_mode_e mode_q, mode_nxt;
  logic clear_d, clear_q;

  // mode is adopted only on a valid sample
  assign mode_nxt = valid_i ? cfg_mode_i : mode_q;

  always_comb begin
    unique case (mode_nxt)
      CCA_FORCE:  clear_d = 1'b1;
      CCA_ENERGY: clear_d = energy_nxt_i;
      CCA_FRAME:  clear_d = !rx_active_i;
      CCA_BOTH:   clear_d = energy_nxt_i && !rx_active_i;
      default:    clear_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= CCA_FORCE;
      clear_q <= 1'b1;
    end else begin
      mode_q  <= mode_nxt;
      clear_q <= clear_d;
    end
  end

  assign clear_o = clear_q;

  p_force_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == CCA_FORCE && !valid_i) |=> clear_q);
  p_rx_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_nxt[1] && rx_active_i) |=> !clear_q);
  p_mode_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(mode_q));
endmodule

// File: rtl/cca_eval.sv
module cca_eval
  import cca_pkg::*;
#(
  parameter int RSSI_W = 8,
  parameter int HYST_W = 3,
  parameter int REG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RSSI_W-1:0] rssi_i,
  input  logic              rssi_valid_i,
  input  logic              rx_active_i,
  input  logic [RSSI_W-1:0] thr_i,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              clear_o
);
  cca_mode_e         cfg_mode;
  logic [HYST_W-1:0] cfg_hyst;
  logic              energy_nxt;

  cca_cfg_reg #(.REG_W(REG_W), .HYST_W(HYST_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .mode_o  (cfg_mode),
    .hyst_o  (cfg_hyst)
  );

  cca_energy_det #(.RSSI_W(RSSI_W), .HYST_W(HYST_W)) u_energy (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rssi_i       (rssi_i),
    .valid_i      (rssi_valid_i),
    .thr_i        (thr_i),
    .hyst_i       (cfg_hyst),
    .energy_nxt_o (energy_nxt)
  );

  cca_decide u_decide (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (rssi_valid_i),
    .rx_active_i  (rx_active_i),
    .cfg_mode_i   (cfg_mode),
    .energy_nxt_i (energy_nxt),
    .clear_o      (clear_o)
  );
endmodule

// File: tb/cca_eval_tb.sv
`timescale 1ns/1ps
module cca_eval_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  rssi_i = '0;
  logic        rssi_valid_i = 1'b0;
  logic        rx_active_i = 1'b0;
  logic [7:0]  thr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        clear_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model state
  int m_cfg_mode = 0, m_hyst = 0, m_act_mode = 0;
  bit m_energy = 0, m_clear = 1;
  logic [31:0] m_rdata = '0;

  always #2 clk_i = ~clk_i;

  cca_eval u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rssi_i(rssi_i), .rssi_valid_i(rssi_valid_i),
    .rx_active_i(rx_active_i), .thr_i(thr_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .clear_o(clear_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int rssi, input bit v, input bit rx, input int thr,
                      input bit wr, input logic [31:0] wd, input string tag);
    bit e_n;
    int mn;
    rssi_i = rssi[7:0]; rssi_valid_i = v; rx_active_i = rx; thr_i = thr[7:0];
    reg_wr_i = wr; reg_wdata_i = wd;
    e_n = m_energy;
    if (v) begin
      if (rssi >= thr) e_n = 0;
      else if (rssi < thr - m_hyst) e_n = 1;
    end
    mn = v ? m_cfg_mode : m_act_mode;
    case (mn)
      0: m_clear = 1;
      1: m_clear = e_n;
      2: m_clear = !rx;
      default: m_clear = e_n && !rx;
    endcase
    m_energy = e_n;
    m_act_mode = mn;
    if (wr) begin
      m_cfg_mode = int'(wd[4:3]);
      m_hyst = int'(wd[2:0]);
      m_rdata = {27'd0, wd[4:0]};
    end
    @(posedge clk_i);
    @(negedge clk_i);
    reg_wr_i = 1'b0;
    chk(tag, {31'd0, clear_o}, {31'd0, m_clear});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 rdata", reg_rdata_o, 32'h0);
    chk("R1 clear", {31'd0, clear_o}, 32'h1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 clear after release", {31'd0, clear_o}, 32'h1);

    // R6: reserved bits read zero, used bits stick
    step(0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R2 force");
    chk("R6 rdata", reg_rdata_o, 32'h0000_001F);
    step(0, 0, 0, 0, 1, 32'hFFFF_FF00 | 32'h0D, "R2 force");
    chk("R6 rdata fields", reg_rdata_o, 32'h0000_000D);

    // R1: held verdict resets busy; mode 1, margin 5, sample in band
    step(0, 0, 0, 0, 1, 32'h0000_000D, "R9 idle");
    step(-2, 1, 0, 0, 0, 0, "R1 reset verdict held busy");
    step(-10, 1, 0, 0, 0, 0, "R3 set clear");
    step(-1, 1, 0, 0, 0, 0, "R3 band hold clear");
    step(50, 0, 0, 0, 0, 0, "R7 no strobe no change");
    step(0, 1, 0, 0, 0, 0, "R3 at thr busy");

    // R10: mode write applies only on next valid; verdict kept
    step(-20, 1, 0, 0, 0, 0, "R3 set clear");
    step(0, 0, 1, 0, 1, 32'h0000_0015, "R10 write mode2 no strobe");
    step(0, 0, 1, 0, 0, 0, "R10 old mode still active");
    step(0, 0, 1, 0, 1, 32'h0000_000D, "R10 rewrite mode1");
    step(-3, 1, 1, 0, 0, 0, "R10 verdict kept across write");
    step(-3, 0, 1, 0, 1, 32'h0000_0015, "R10 write mode2");
    step(-3, 1, 1, 0, 0, 0, "R4 frame busy after valid");
    step(-3, 0, 0, 0, 0, 0, "R4 no frame clear no strobe");

    // R8: thr -125, margin 7 -> -132, nothing below
    step(0, 0, 0, -125, 1, 32'h0000_000F, "R9 idle");
    step(100, 1, 0, -125, 0, 0, "R3 busy");
    step(-128, 1, 0, -125, 0, 0, "R8 no wrap hold busy");
    step(-126, 1, 0, -125, 0, 0, "R8 no wrap hold busy");

    // sweep: modes x margins x thresholds, ramp up then down
    for (int m = 0; m < 4; m++) begin
      for (int hi = 0; hi < 3; hi++) begin
        for (int ti = 0; ti < 4; ti++) begin
          int h, t;
          string tag;
          h = (hi == 0) ? 0 : (hi == 1) ? 3 : 7;
          t = (ti == 0) ? -128 : (ti == 1) ? -70 : (ti == 2) ? 0 : 127;
          tag = (m == 0) ? "R2 sweep" : (m == 1) ? "R3 sweep" : (m == 2) ? "R4 sweep" : "R5 sweep";
          step(0, 0, 0, t, 1, {27'd0, m[1:0], h[2:0]}, tag);
          for (int r = -128; r < 128; r++)
            step(r, (r % 5) != 0, ((r + 200) % 23) < 3, t, 0, 0, tag);
          for (int r = 127; r >= -128; r--)
            step(r, (r % 7) != 0, ((r + 200) % 19) < 2, t, 0, 0, tag);
          chk("R6 sweep rdata", reg_rdata_o, m_rdata);
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule